// File: doc/BRIEF.md
# Inbound Stream Packet Serializer

This block builds the serial inbound frame that an audio codec sends back to its controller on one data line. A frame always begins with a 36-bit response word. When a sample block is ready, one stream packet follows it. The packet carries a 4-bit stream tag, a 6-bit byte count, the sample bits and zero padding up to the next byte boundary. Every remaining bit time of the frame is driven low.

A frame-start strobe captures the response word, the tag and the sample block, along with its count and per-sample width. The serializer then puts out one bit on each rising clock edge for a fixed number of bit times. A request whose byte count is more than the length field can hold, or more than the frame can carry, is refused. That frame sends only the response word, and an error flag is raised for the rest of the frame.

Top module: `ibs_serializer`

## Requirements
- R1: After reset, `sdi_o` and `len_err_o` are 0, and `sdi_o` stays 0 until the first frame-start strobe.
- R2: Frame bit k (k = 0 is the bit after the strobe edge) appears on `sdi_o` after the (k+1)-th rising edge following the strobe edge. Bits 0..35 are the response word, most significant bit first.
- R3: When a packet is sent, bits 36..39 carry the stream tag, most significant bit first.
- R4: Bits 40..45 carry the byte count ceil(cnt*w/8), most significant bit first, where cnt is the sample count and w the sample width in bits.
- R5: From bit 46 onward the samples follow in order, sample 0 first. Each sample is sent from bit w-1 down to bit 0. Sample j occupies `smp_data_i[j*SMP_W +: SMP_W]`, and bits above w-1 in each slot are ignored.
- R6: After the last sample bit, zeros pad the packet to 46 + 8*count bits, and zeros fill the frame up to bit FRAME_BITS-1.
- R7: With `blk_valid_i` low at the strobe, the frame carries only the response word followed by zeros, and `len_err_o` is 0.
- R8: A valid request whose byte count exceeds min(63, floor((FRAME_BITS-46)/8)) (56 by default) sets `len_err_o` for that frame and sends only the response word. A count at exactly the limit is accepted.
- R9: A strobe in the middle of a frame abandons that frame and starts a new one at bit 0.
- R10: After FRAME_BITS bit times, `sdi_o` stays 0 until the next strobe.
- R11: A sample count above N_SMP is treated as N_SMP, and a sample width above SMP_W is treated as SMP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame-start strobe, captures all request inputs |
| resp_i | input | RESP_W (36) | Response word |
| blk_valid_i | input | 1 | A sample block is ready for this frame |
| tag_i | input | TAG_W (4) | Stream tag |
| smp_cnt_i | input | CNT_W (5) | Number of samples |
| smp_w_i | input | SW_W (6) | Sample width in bits |
| smp_data_i | input | N_SMP*SMP_W (512) | Sample slots, right-justified |
| sdi_o | output | 1 | Serial inbound data |
| len_err_o | output | 1 | Request refused for this frame |

## Verification
The bench uses the default parameters: 500 bit times per frame, 16 sample slots of up to 32 bits. With these values the byte limit set by the frame (56) is tighter than the one set by the 6-bit field. This lets the bench place requests just at the limit (14 samples of 32 bits) and just above it (15 of 30, 16 of 32). Odd widths such as 7 and 20 bits produce partial-byte padding. A zero-sample packet and a single 1-bit sample cover the smallest cases.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
  typedef enum logic [2:0] {
    PH_RESP,
    PH_TAG,
    PH_LEN,
    PH_DATA,
    PH_PAD,
    PH_IDLE
  } phase_e;
endpackage

// File: rtl/ibs_phase.sv
module ibs_phase
  import ibs_pkg::*;
#(
  parameter int RESP_W = 36,
  parameter int TAG_W  = 4,
  parameter int LEN_W  = 6,
  parameter int POS_W  = 9,
  parameter int PAY_W  = 10
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             pkt_i,
  input  logic [PAY_W-1:0] pay_i,
  input  logic [LEN_W-1:0] len_i,
  output phase_e           phase_o,
  output logic [POS_W-1:0] sel_o
);
  localparam int HDR_END = RESP_W + TAG_W + LEN_W;
  localparam int EW = ((POS_W > PAY_W) ? POS_W : PAY_W) + 3;

  logic [EW-1:0] p, data_end, pad_end;

  always_comb begin
    p        = EW'(pos_i);
    data_end = EW'(HDR_END) + EW'(pay_i);
    pad_end  = EW'(HDR_END) + (EW'(len_i) << 3);
    phase_o  = PH_IDLE;
    sel_o    = '0;
    if (p < EW'(RESP_W)) begin
      phase_o = PH_RESP;
      sel_o   = POS_W'(EW'(RESP_W - 1) - p);
    end else if (!pkt_i) begin
      phase_o = PH_IDLE;
    end else if (p < EW'(RESP_W + TAG_W)) begin
      phase_o = PH_TAG;
      sel_o   = POS_W'(EW'(RESP_W + TAG_W - 1) - p);
    end else if (p < EW'(HDR_END)) begin
      phase_o = PH_LEN;
      sel_o   = POS_W'(EW'(HDR_END - 1) - p);
    end else if (p < data_end) begin
      phase_o = PH_DATA;
    end else if (p < pad_end) begin
      phase_o = PH_PAD;
    end
  end
endmodule

// File: rtl/ibs_walker.sv
module ibs_walker #(
  parameter int N_SMP = 16,
  parameter int SMP_W = 32,
  parameter int CNT_W = 5,
  parameter int SW_W  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [SW_W-1:0]        w_i,
  input  logic                   adv_i,
  input  logic [N_SMP*SMP_W-1:0] data_i,
  output logic                   bit_o
);
  localparam int BIT_W = (SMP_W > 1) ? $clog2(SMP_W) : 1;
  localparam int IW    = $clog2(N_SMP * SMP_W) + 1;

  logic [CNT_W-1:0] idx_q;
  logic [BIT_W-1:0] bit_q, wm1_q;
  logic [IW-1:0]    flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      bit_q <= '0;
      wm1_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      bit_q <= BIT_W'(w_i - SW_W'(1));
      wm1_q <= BIT_W'(w_i - SW_W'(1));
    end else if (adv_i) begin
      if (bit_q == '0) begin
        idx_q <= idx_q + CNT_W'(1);
        bit_q <= wm1_q;
      end else begin
        bit_q <= bit_q - BIT_W'(1);
      end
    end
  end

  always_comb begin
    flat  = IW'(idx_q) * IW'(SMP_W) + IW'(bit_q);
    bit_o = (idx_q < CNT_W'(N_SMP)) ? data_i[flat] : 1'b0;
  end
endmodule

// File: rtl/ibs_serializer.sv
module ibs_serializer
  import ibs_pkg::*;
#(
  parameter int FRAME_BITS = 500,
  parameter int RESP_W     = 36,
  parameter int TAG_W      = 4,
  parameter int LEN_W      = 6,
  parameter int N_SMP      = 16,
  parameter int SMP_W      = 32,
  parameter int CNT_W      = $clog2(N_SMP + 1),
  parameter int SW_W       = $clog2(SMP_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_start_i,
  input  logic [RESP_W-1:0]      resp_i,
  input  logic                   blk_valid_i,
  input  logic [TAG_W-1:0]       tag_i,
  input  logic [CNT_W-1:0]       smp_cnt_i,
  input  logic [SW_W-1:0]        smp_w_i,
  input  logic [N_SMP*SMP_W-1:0] smp_data_i,
  output logic                   sdi_o,
  output logic                   len_err_o
);
  localparam int POS_W   = $clog2(FRAME_BITS + 1);
  localparam int PAY_W   = $clog2(N_SMP * SMP_W + 1);
  localparam int PW      = CNT_W + SW_W + 1;
  localparam int HDR_END = RESP_W + TAG_W + LEN_W;
  localparam int LEN_CAP = (1 << LEN_W) - 1;
  localparam int FIT_LEN = (FRAME_BITS - HDR_END) / 8;
  localparam int MAX_LEN = (LEN_CAP < FIT_LEN) ? LEN_CAP : FIT_LEN;

  logic [CNT_W-1:0]       cnt_c;
  logic [SW_W-1:0]        w_c;
  logic [PW-1:0]          prod_c, len_full_c;
  logic                   err_c;

  logic [POS_W-1:0]       pos_q;
  logic [RESP_W-1:0]      resp_q;
  logic [TAG_W-1:0]       tag_q;
  logic [LEN_W-1:0]       len_q;
  logic [PAY_W-1:0]       pay_q;
  logic                   pkt_q;
  logic [N_SMP*SMP_W-1:0] data_q;

  phase_e                 phase;
  logic [POS_W-1:0]       sel;
  logic                   walk_bit, nxt_bit;

  // request decode, R4 / R8 / R11
  always_comb begin
    cnt_c      = (smp_cnt_i > CNT_W'(N_SMP)) ? CNT_W'(N_SMP) : smp_cnt_i;
    w_c        = (smp_w_i > SW_W'(SMP_W)) ? SW_W'(SMP_W) : smp_w_i;
    prod_c     = PW'(cnt_c) * PW'(w_c);
    len_full_c = (prod_c + PW'(7)) >> 3;
    err_c      = blk_valid_i && (len_full_c > PW'(MAX_LEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= POS_W'(FRAME_BITS);
      resp_q    <= '0;
      tag_q     <= '0;
      len_q     <= '0;
      pay_q     <= '0;
      pkt_q     <= 1'b0;
      data_q    <= '0;
      len_err_o <= 1'b0;
    end else if (frame_start_i) begin
      pos_q     <= '0;
      resp_q    <= resp_i;
      tag_q     <= tag_i;
      len_q     <= LEN_W'(len_full_c);
      pay_q     <= PAY_W'(prod_c);
      pkt_q     <= blk_valid_i && !err_c;
      data_q    <= smp_data_i;
      len_err_o <= err_c;
    end else if (pos_q != POS_W'(FRAME_BITS)) begin
      pos_q <= pos_q + POS_W'(1);
    end
  end

  ibs_phase #(
    .RESP_W(RESP_W), .TAG_W(TAG_W), .LEN_W(LEN_W), .POS_W(POS_W), .PAY_W(PAY_W)
  ) u_phase (
    .pos_i  (pos_q),
    .pkt_i  (pkt_q),
    .pay_i  (pay_q),
    .len_i  (len_q),
    .phase_o(phase),
    .sel_o  (sel)
  );

  ibs_walker #(
    .N_SMP(N_SMP), .SMP_W(SMP_W), .CNT_W(CNT_W), .SW_W(SW_W)
  ) u_walker (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(frame_start_i),
    .w_i   (w_c),
    .adv_i (phase == PH_DATA && !frame_start_i),
    .data_i(data_q),
    .bit_o (walk_bit)
  );

  always_comb begin
    unique case (phase)
      PH_RESP: nxt_bit = resp_q[sel];
      PH_TAG:  nxt_bit = tag_q[sel];
      PH_LEN:  nxt_bit = len_q[sel];
      PH_DATA: nxt_bit = walk_bit;
      default: nxt_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdi_o <= 1'b0;
    else         sdi_o <= nxt_bit;
  end
endmodule

// File: rtl/ibs_serializer_chk.sv
module ibs_serializer_chk #(
  parameter int FRAME_BITS = 500,
  parameter int CNT_W      = 5,
  parameter int POS_W      = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             blk_valid_i,
  input logic [CNT_W-1:0] smp_cnt_i,
  input logic [POS_W-1:0] pos_q,
  input logic             sdi_o,
  input logic             len_err_o
);
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> pos_q == '0);

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(FRAME_BITS) && !frame_start_i) |=> !sdi_o);

  assert_no_blk_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !blk_valid_i) |=> !len_err_o);

  assert_err_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(len_err_o));

  assert_small_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && smp_cnt_i <= CNT_W'(1)) |=> !len_err_o);
endmodule

bind ibs_serializer ibs_serializer_chk #(
  .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .POS_W(POS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .blk_valid_i  (blk_valid_i),
  .smp_cnt_i    (smp_cnt_i),
  .pos_q        (pos_q),
  .sdi_o        (sdi_o),
  .len_err_o    (len_err_o)
);

// File: tb/ibs_serializer_tb.sv
module ibs_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 500;
  localparam int MAXLEN = 56;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_start_i = 1'b0;
  logic [35:0] resp_i = '0;
  logic blk_valid_i = 1'b0;
  logic [3:0] tag_i = '0;
  logic [4:0] smp_cnt_i = '0;
  logic [5:0] smp_w_i = '0;
  logic [511:0] smp_data_i = '0;
  logic sdi_o, len_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibs_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i), .resp_i(resp_i),
    .blk_valid_i(blk_valid_i), .tag_i(tag_i), .smp_cnt_i(smp_cnt_i), .smp_w_i(smp_w_i),
    .smp_data_i(smp_data_i), .sdi_o(sdi_o), .len_err_o(len_err_o)
  );

  // {valid, tag, cnt, width, resp, seed}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 4'h5, 5'd4,  6'd16, 36'h9_A5C3_1E7F, 16'h1234},
    {1'b1, 4'hA, 5'd3,  6'd20, 36'h0_FFFF_0001, 16'h00F1},
    {1'b1, 4'h3, 5'd5,  6'd7,  36'hF_0000_FFFF, 16'hBEEF},
    {1'b0, 4'h7, 5'd4,  6'd8,  36'h5_5555_AAAA, 16'h4444},
    {1'b1, 4'hC, 5'd16, 6'd32, 36'h1_2345_6789, 16'h0F0F},
    {1'b1, 4'h9, 5'd14, 6'd32, 36'hA_BCDE_F012, 16'h7777},
    {1'b1, 4'h6, 5'd15, 6'd30, 36'h3_3333_CCCC, 16'h2222},
    {1'b1, 4'hF, 5'd0,  6'd8,  36'h8_0000_0001, 16'h0101},
    {1'b1, 4'h1, 5'd1,  6'd1,  36'h7_FFFF_FFFE, 16'h0003}
  };

  logic exp_bits [FRAME];
  int   exp_reg  [FRAME];  // 0 resp, 1 tag, 2 len, 3 data, 4 pad/fill

  function automatic logic [511:0] gen_data(input int seed);
    logic [511:0] v;
    for (int j = 0; j < 16; j++)
      v[j*32 +: 32] = 32'(seed * 32'h0100_0193 + j * 32'h9E37_79B9) ^ 32'(j << 7);
    return v;
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // cnt/width given after clamping
  function automatic bit build(input bit vld, input logic [3:0] tag, input int cnt,
                               input int w, input logic [35:0] resp, input logic [511:0] d);
    int idx, len;
    bit err;
    len = (cnt * w + 7) / 8;
    err = vld && (len > MAXLEN);
    for (int k = 0; k < FRAME; k++) begin exp_bits[k] = 1'b0; exp_reg[k] = 4; end
    idx = 0;
    for (int b = 35; b >= 0; b--) begin exp_bits[idx] = resp[b]; exp_reg[idx] = 0; idx++; end
    if (vld && !err) begin
      for (int b = 3; b >= 0; b--) begin exp_bits[idx] = tag[b]; exp_reg[idx] = 1; idx++; end
      for (int b = 5; b >= 0; b--) begin exp_bits[idx] = len[b]; exp_reg[idx] = 2; idx++; end
      for (int j = 0; j < cnt; j++)
        for (int b = w - 1; b >= 0; b--) begin
          exp_bits[idx] = d[j*32 + b]; exp_reg[idx] = 3; idx++;
        end
    end
    return err;
  endfunction

  task automatic strobe(input logic [67:0] v, input logic [511:0] d);
    @(negedge clk);
    {blk_valid_i, tag_i, smp_cnt_i, smp_w_i, resp_i} = v[67:16];
    smp_data_i = d;
    frame_start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic run_frame(input int id, input logic [67:0] v, input int cnt_eff, input int w_eff);
    logic [511:0] d;
    bit exp_err;
    int bad [5];
    d = gen_data(int'(v[15:0]));
    exp_err = build(v[67], v[66:63], cnt_eff, w_eff, v[51:16], d);
    strobe(v, d);
    check($sformatf("R8 frame %0d len_err_o", id), len_err_o == exp_err, len_err_o, exp_err);
    foreach (bad[i]) bad[i] = 0;
    for (int k = 0; k < FRAME; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sdi_o !== exp_bits[k]) bad[exp_reg[k]]++;
    end
    check($sformatf("R2 frame %0d response bits wrong", id), bad[0] == 0, bad[0], 0);
    check($sformatf("R3 frame %0d tag bits wrong", id), bad[1] == 0, bad[1], 0);
    check($sformatf("R4 frame %0d length bits wrong", id), bad[2] == 0, bad[2], 0);
    check($sformatf("R5 frame %0d sample bits wrong", id), bad[3] == 0, bad[3], 0);
    check($sformatf("R6 frame %0d pad/fill bits wrong", id), bad[4] == 0, bad[4], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int zeros;
    logic [67:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state and idle until first strobe
    check("R1 sdi_o after reset", sdi_o == 1'b0, sdi_o, 0);
    check("R1 len_err_o after reset", len_err_o == 1'b0, len_err_o, 0);
    zeros = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (sdi_o == 1'b0) zeros++; end
    check("R1 sdi_o idle before strobe (low cycles)", zeros == 20, zeros, 20);

    for (int i = 0; i < NV; i++)
      run_frame(i, VEC[i], int'(VEC[i][62:58]), int'(VEC[i][57:52]));

    // R10 idle after frame end
    zeros = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (sdi_o == 1'b0) zeros++; end
    check("R10 sdi_o low after frame end", zeros == 30, zeros, 30);

    // R9 restart mid-frame
    strobe(VEC[0], gen_data(int'(VEC[0][15:0])));
    repeat (100) @(negedge clk);
    run_frame(100, VEC[1], 3, 20);

    // R7 error flag cleared by a no-block frame after a refused one
    run_frame(101, VEC[4], 16, 32);
    run_frame(102, VEC[3], 4, 8);

    // R11 clamps: count 31 -> 16, width 40 -> 32, 8 bytes per 2 samples
    v = {1'b1, 4'h2, 5'd31, 6'd8, 36'h0_1234_5678, 16'h0055};
    run_frame(103, v, 16, 8);
    v = {1'b1, 4'h4, 5'd2, 6'd40, 36'hC_0000_0003, 16'h0066};
    run_frame(104, v, 2, 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule